// File: doc/BRIEF.md
# Master-role audio frame and bit clock generator

This block produces the two timing signals of a two-channel serial audio link, a frame clock that selects the left or right channel and a bit clock with 64 periods per frame, from a single master clock. A two-bit mode input picks single, double or quad speed, or hands the link to an external timing master. In that last case the generator stays idle and turns its output enables off, so that the pins can be driven from outside. A ratio input reports whether the master clock runs at the higher of the two supported rates for the chosen speed. In single and double speed this engages a fractional divide-by-1.5 stage, built as a clock enable, ahead of the integer dividers.

The block also gives a serializer a one-cycle strobe at every falling edge of the bit clock. The serializer uses it to launch the next data bit without sampling the bit clock itself. Mode and ratio are captured only while reset is active. The clock relations therefore cannot change during a run, and a new setting is applied at the next reset.

Top module: `audclk_master_gen`

## Requirements
- R1: The mode code `mode_sel` is decoded as follows: 2'b00 single speed, 2'b01 double speed, 2'b10 quad speed, all three as timing master with `frame_oe` and `bit_oe` high. 2'b11 is the follower role, in which both enables are low.
- R2: In single speed, one bit-clock period lasts 4 divider ticks (2 low, then 2 high), and one frame lasts 256 ticks.
- R3: In double speed, one bit-clock period lasts 2 divider ticks (1 low, then 1 high), and one frame lasts 128 ticks.
- R4: In quad speed, one bit-clock period lasts 3 master-clock cycles: low for 2 cycles, then high for 1, which is a one-third duty. A frame lasts 64 bit periods (192 cycles), and `fast_ratio` has no effect.
- R5: In single or double speed with `fast_ratio` = 1, the divider ticks on the first two of every three master-clock cycles, counted from reset release. With `fast_ratio` = 0 it ticks on every cycle.
- R6: `frame_clk` is high (left) for the first 32 bit periods after reset release and low for the next 32, then repeats. It changes only in the cycle in which `bit_clk` falls.
- R7: `fall_stb` is high for exactly the one cycle that follows each high-to-low change of `bit_clk`, and is low at all other times.
- R8: In the follower role the counters stay idle: `frame_clk` holds 1, `bit_clk` holds 0 and `fall_stb` holds 0.
- R9: `mode_sel` and `fast_ratio` are sampled only while reset is active. Changes to them during a run have no effect until the next reset.
- R10: During reset and in the first cycle after release, `frame_clk` = 1, `bit_clk` = 0 and `fall_stb` = 0, and all counters start from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_sel | input | 2 | Speed and role code, captured during reset |
| fast_ratio | input | 1 | High when the master clock runs at the higher ratio; captured during reset |
| frame_clk | output | 1 | Frame clock, high for the left channel |
| bit_clk | output | 1 | Bit clock, 64 periods per frame |
| frame_oe | output | 1 | Output enable for the frame clock pin |
| bit_oe | output | 1 | Output enable for the bit clock pin |
| fall_stb | output | 1 | One-cycle strobe after each bit-clock falling edge |

## Verification
The assertions check on every cycle the relations between the outputs. The strobe coincides exactly with bit-clock falls, the frame clock moves only on such a fall, the follower role keeps every output quiet, and the role stays fixed after reset release. Only the bench scenarios can show the actual periods, duty cycles and tick patterns for each speed with and without the prescaler, the left-first frame phase after reset, and that a mode change made during a run is ignored until the next reset.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    ROLE_SLAVE = 2'b11
  } clk_mode_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/audclk_rst_sync.sv
module audclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);

  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign run_n = shift_q[STAGES-1];

endmodule

// File: rtl/audclk_prescaler.sv
module audclk_prescaler #(
  parameter int PERIOD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (en) begin
      if (ph_q == LAST) ph_d = '0;
      else              ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // the last phase of each group is swallowed
  assign tick = (ph_q != LAST);

endmodule

// File: rtl/audclk_divider.sv
module audclk_divider #(
  parameter int BIT_W     = 3,
  parameter int SLOT_HALF = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [BIT_W-1:0] bit_len,
  input  logic [BIT_W-1:0] hi_start,
  output logic             bit_clk,
  output logic             frame_clk,
  output logic             fall_stb
);

  localparam int SLOT_W = $clog2(2 * SLOT_HALF);
  localparam logic [BIT_W-1:0]  B_ONE = BIT_W'(1);
  localparam logic [SLOT_W-1:0] S_ONE = SLOT_W'(1);

  logic [BIT_W-1:0]  bph_q, bph_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              bit_q, bit_d;
  logic              frame_q, frame_d;
  logic              stb_q, stb_d;

  always_comb begin
    bph_d  = bph_q;
    slot_d = slot_q;
    if (run && tick) begin
      if (bph_q == bit_len - B_ONE) begin
        bph_d  = '0;
        slot_d = slot_q + S_ONE;
      end else begin
        bph_d  = bph_q + B_ONE;
      end
    end
    bit_d   = (bph_d >= hi_start);
    frame_d = ~slot_d[SLOT_W-1];
    stb_d   = bit_q & ~bit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bph_q   <= '0;
      slot_q  <= '0;
      bit_q   <= 1'b0;
      frame_q <= 1'b1;
      stb_q   <= 1'b0;
    end else begin
      bph_q   <= bph_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
      stb_q   <= stb_d;
    end
  end

  assign bit_clk   = bit_q;
  assign frame_clk = frame_q;
  assign fall_stb  = stb_q;

endmodule

// File: rtl/audclk_master_gen.sv
module audclk_master_gen
  import audclk_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PRE_PERIOD   = 3,
  parameter int SGL_TICKS    = 4,
  parameter int DBL_TICKS    = 2,
  parameter int QUAD_CYCLES  = 3,
  parameter int QUAD_HI      = 1,
  parameter int SLOT_HALF    = 32
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       fast_ratio,
  output logic       frame_clk,
  output logic       bit_clk,
  output logic       frame_oe,
  output logic       bit_oe,
  output logic       fall_stb
);

  localparam int MAX_LEN = max3(SGL_TICKS, DBL_TICKS, QUAD_CYCLES);
  localparam int BIT_W   = $clog2(MAX_LEN + 1);

  logic             run_n;
  clk_mode_e        mode_q;
  logic             fast_q;
  logic             master;
  logic             pre_en;
  logic             pre_tick;
  logic             tick;
  logic [BIT_W-1:0] bit_len;
  logic [BIT_W-1:0] hi_start;

  audclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (mclk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  // configuration is only taken while reset holds the block
  always_ff @(posedge mclk) begin
    if (!run_n) begin
      mode_q <= clk_mode_e'(mode_sel);
      fast_q <= fast_ratio;
    end
  end

  always_comb begin
    master   = (mode_q != ROLE_SLAVE);
    pre_en   = master && fast_q && (mode_q != SPD_QUAD);
    bit_len  = BIT_W'(SGL_TICKS);
    hi_start = BIT_W'(SGL_TICKS / 2);
    case (mode_q)
      SPD_DOUBLE: begin
        bit_len  = BIT_W'(DBL_TICKS);
        hi_start = BIT_W'(DBL_TICKS / 2);
      end
      SPD_QUAD: begin
        bit_len  = BIT_W'(QUAD_CYCLES);
        hi_start = BIT_W'(QUAD_CYCLES - QUAD_HI);
      end
      default: begin
        bit_len  = BIT_W'(SGL_TICKS);
        hi_start = BIT_W'(SGL_TICKS / 2);
      end
    endcase
    tick = pre_en ? pre_tick : 1'b1;
  end

  audclk_prescaler #(.PERIOD(PRE_PERIOD)) u_pre (
    .clk   (mclk),
    .rst_n (run_n),
    .en    (pre_en),
    .tick  (pre_tick)
  );

  audclk_divider #(.BIT_W(BIT_W), .SLOT_HALF(SLOT_HALF)) u_div (
    .clk       (mclk),
    .rst_n     (run_n),
    .run       (master),
    .tick      (tick),
    .bit_len   (bit_len),
    .hi_start  (hi_start),
    .bit_clk   (bit_clk),
    .frame_clk (frame_clk),
    .fall_stb  (fall_stb)
  );

  assign frame_oe = master;
  assign bit_oe   = master;

endmodule

// File: rtl/audclk_master_gen_chk.sv
module audclk_master_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_n,
  input logic frame_clk,
  input logic bit_clk,
  input logic fall_stb,
  input logic frame_oe
);

  AST_STB_AFTER_FALL: assert property (@(posedge clk) disable iff (!run_n)
    fall_stb |-> (!bit_clk && $past(bit_clk))); // R7

  AST_FALL_GIVES_STB: assert property (@(posedge clk) disable iff (!run_n)
    $fell(bit_clk) |-> fall_stb); // R7

  AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (!run_n)
    (frame_clk != $past(frame_clk)) |-> fall_stb); // R6

  AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_oe |-> (!bit_clk && frame_clk && !fall_stb)); // R8

  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!run_n)
    $stable(frame_oe)); // R9

endmodule

bind audclk_master_gen audclk_master_gen_chk u_chk (
  .clk       (mclk),
  .rst_n     (rst_n),
  .run_n     (run_n),
  .frame_clk (frame_clk),
  .bit_clk   (bit_clk),
  .fall_stb  (fall_stb),
  .frame_oe  (frame_oe)
);

// File: tb/audclk_master_gen_bench.sv
`timescale 1ns/1ps
module audclk_master_gen_bench;

  logic       mclk;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       fast_ratio;
  logic       frame_clk, bit_clk, frame_oe, bit_oe, fall_stb;

  int checks;
  int fails;

  audclk_master_gen u_audclk_master_gen (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .fast_ratio (fast_ratio),
    .frame_clk  (frame_clk),
    .bit_clk    (bit_clk),
    .frame_oe   (frame_oe),
    .bit_oe     (bit_oe),
    .fall_stb   (fall_stb)
  );

  initial mclk = 1'b0;
  always #5 mclk = ~mclk;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ticks seen after k counting edges
  function automatic int ticks_after(input int mode, input int fast, input int k);
    if (mode != 2 && fast != 0) return 2 * (k / 3) + (k % 3);
    return k;
  endfunction

  function automatic int exp_bit(input int mode, input int fast, input int k);
    int t, len, hi;
    t   = ticks_after(mode, fast, k);
    len = (mode == 0) ? 4 : (mode == 1) ? 2 : 3;
    hi  = (mode == 0) ? 2 : (mode == 1) ? 1 : 2;
    if (mode == 3) return 0;
    return ((t % len) >= hi) ? 1 : 0;
  endfunction

  function automatic int exp_frame(input int mode, input int fast, input int k);
    int t, len;
    t   = ticks_after(mode, fast, k);
    len = (mode == 0) ? 4 : (mode == 1) ? 2 : 3;
    if (mode == 3) return 1;
    return (((t / len) % 64) < 32) ? 1 : 0;
  endfunction

  // reset with given pins; returns at the negedge where k = 0
  task automatic do_reset(input logic [1:0] m, input logic f);
    @(negedge mclk);
    rst_n      = 1'b0;
    mode_sel   = m;
    fast_ratio = f;
    repeat (3) begin
      @(negedge mclk);
      chk("R10", frame_clk, 1, "frame_clk in reset");
      chk("R10", bit_clk,   0, "bit_clk in reset");
      chk("R10", fall_stb,  0, "fall_stb in reset");
    end
    rst_n = 1'b1;
    @(posedge mclk);
    @(posedge mclk);
    @(negedge mclk);
  endtask

  task automatic run_model(input string tag, input int mode, input int fast,
                           input int start_k, input int ncyc);
    int prev_bit;
    prev_bit = (start_k == 0) ? 0 : exp_bit(mode, fast, start_k - 1);
    for (int k = start_k; k < start_k + ncyc; k++) begin
      int eb;
      eb = exp_bit(mode, fast, k);
      chk(tag,  bit_clk,   eb, "bit_clk");
      chk("R6", frame_clk, exp_frame(mode, fast, k), "frame_clk");
      chk("R7", fall_stb,  (prev_bit == 1 && eb == 0) ? 1 : 0, "fall_stb");
      prev_bit = eb;
      @(negedge mclk);
    end
  endtask

  task automatic test_speed(input string tag, input int mode, input int fast, input int ncyc);
    do_reset(mode[1:0], fast[0]);
    chk("R10", frame_clk, 1, "frame_clk first cycle");
    chk("R10", bit_clk,   0, "bit_clk first cycle");
    chk("R1",  frame_oe,  1, "frame_oe master");
    chk("R1",  bit_oe,    1, "bit_oe master");
    run_model(tag, mode, fast, 0, ncyc);
  endtask

  task automatic test_follower();
    do_reset(2'b11, 1'b1);
    for (int k = 0; k < 100; k++) begin
      chk("R1", frame_oe, 0, "frame_oe follower");
      chk("R1", bit_oe,   0, "bit_oe follower");
      chk("R8", frame_clk, 1, "frame_clk follower");
      chk("R8", bit_clk,   0, "bit_clk follower");
      chk("R8", fall_stb,  0, "fall_stb follower");
      @(negedge mclk);
    end
  endtask

  task automatic test_mode_change();
    do_reset(2'b00, 1'b0);
    run_model("R2", 0, 0, 0, 100);
    mode_sel   = 2'b10;
    fast_ratio = 1'b1;
    run_model("R9", 0, 0, 100, 500);
    chk("R9", frame_oe, 1, "frame_oe after pin change");
    mode_sel = 2'b11;
    run_model("R9", 0, 0, 600, 50);
    chk("R9", frame_oe, 1, "role after pin change");
    do_reset(2'b11, 1'b0);
    chk("R9", frame_oe, 0, "role after new reset");
    do_reset(2'b01, 1'b1);
    run_model("R9", 1, 1, 0, 300);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks     = 0;
    fails      = 0;
    rst_n      = 1'b0;
    mode_sel   = 2'b00;
    fast_ratio = 1'b0;
    test_speed("R2", 0, 0, 600);      // single, every cycle ticks
    test_speed("R2/R5", 0, 1, 900);   // single with prescaler
    test_speed("R3", 1, 0, 300);      // double
    test_speed("R3/R5", 1, 1, 450);   // double with prescaler
    test_speed("R4", 2, 0, 420);      // quad
    test_speed("R4", 2, 1, 420);      // quad, ratio input ignored
    test_follower();
    test_mode_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule